// File: doc/BRIEF.md
# Bit-Scan and Zero-Count Execution Unit

This unit is a pipelined datapath that finds set bits in an integer operand. Each operation brings an operand, a size select, a two-bit operation code and the current contents of the destination register. The unit has four operations. Forward scan returns the position of the lowest set bit. Reverse scan returns the position of the highest set bit. Leading-zero count and trailing-zero count give the number of zero bits above the highest set bit or below the lowest set bit.

The operand is cut to 16, 32 or 64 bits before the search, and any bits above the chosen size have no effect. When nothing is set within the chosen size, a scan hands back the old destination value with the zero flag raised. A count returns the operand width and raises the carry flag instead. The search is a fixed-depth priority tree and does not walk through the bits. Every result therefore appears exactly three cycles after issue, whatever the data, and the unit can take a new operation every cycle.

Top module: `bitscan_unit`

## Requirements
- R1: Operation code 2'b00 (forward scan) on a source that is nonzero within the selected size returns the index of its least significant set bit, zero-extended to 64 bits, with the zero flag and the carry flag both 0.
- R2: Operation code 2'b01 (reverse scan) on a source that is nonzero within the selected size returns the index of its most significant set bit, zero-extended, with both flags 0. For example, 16'h0024 gives 5.
- R3: For either scan code (2'b00, 2'b01), when the source is zero within the selected size, the result is the full 64-bit destination value supplied with the operation, the zero flag is 1 and the carry flag is 0.
- R4: Operation code 2'b10 (leading-zero count) on a nonzero source returns the selected width minus one minus the most significant set-bit index.
- R5: For either count code (2'b10, 2'b11), a source that is zero within the selected size gives the selected width (16, 32 or 64) with the carry flag 1. The carry flag is 0 in every other case, and always 0 for the scan codes.
- R6: Operation code 2'b11 (trailing-zero count) on a nonzero source returns the index of the least significant set bit.
- R7: For the count codes, the zero flag is 1 exactly when the returned count is 0.
- R8: The size select 2'b00 picks 16 bits, 2'b01 picks 32 bits, and 2'b10 or 2'b11 pick 64 bits. Source bits at or above the selected width do not affect result or flags.
- R9: An operation presented with in_valid high in cycle t shows up with out_valid high in cycle t+3, and out_valid is low in cycle t+3 when in_valid was low in cycle t. in_ready is always high, so back-to-back issue every cycle gives back-to-back results in order.
- R10: While rst_n is low at a clock edge, out_valid, out_result, out_zf and out_cf are all 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_ready | output | 1 | Unit accepts an operation (always 1) |
| in_op | input | 2 | Operation code |
| in_size | input | 2 | Operand size select |
| in_src | input | 64 | Source operand |
| in_dst_old | input | 64 | Current destination value, returned by a scan of zero |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 64 | Index, count or kept destination value |
| out_zf | output | 1 | Zero flag |
| out_cf | output | 1 | Carry flag (count of an empty source) |

## Verification
The bench drives every pair of set-bit positions, single bits included, with all four operations and all three sizes. Junk bits sit above the selected width. A design that forgot the mask would report an index above the width or see a nonzero source where the true value is zero. Sources that are empty within the width check two things: that a scan keeps the old destination with the zero flag up, and that a count returns 16, 32 or 64 with carry set. A design that mixed these up would overwrite the destination or return a stray index. The 16-bit case also exposes a leading-zero count computed against the full 64 bits. A back-to-back stream with changing operations checks that results stay three cycles behind and in order.

// File: rtl/bitscan_pkg.sv
// Package: shared encodings for the bit-scan unit.
// Assumes a 2-bit operation code and a 2-bit size select; the size code 2'b11
// is treated the same as the full-width code.
package bitscan_pkg;

    typedef enum logic [1:0] {
        OP_SCAN_FWD  = 2'b00,
        OP_SCAN_REV  = 2'b01,
        OP_LEAD_ZC   = 2'b10,
        OP_TRAIL_ZC  = 2'b11
    } bs_op_e;

    typedef enum logic [1:0] {
        SZ_QUARTER = 2'b00,
        SZ_HALF    = 2'b01,
        SZ_FULL    = 2'b10,
        SZ_ALT     = 2'b11
    } bs_size_e;

    // Number of operand bits selected by a size code, given the full width.
    function automatic int unsigned sel_bits(bs_size_e sz, int unsigned full);
        case (sz)
            SZ_QUARTER: return full / 4;
            SZ_HALF:    return full / 2;
            default:    return full;
        endcase
    endfunction

    // True for the two scan operations, which keep the destination on zero.
    function automatic logic is_scan(bs_op_e op);
        return (op == OP_SCAN_FWD) || (op == OP_SCAN_REV);
    endfunction

endpackage

// File: rtl/bs_operand_mask.sv
// Module: bs_operand_mask
// Clears every operand bit at or above the width picked by the size code.
// Assumes DATA_W is divisible by 4 (quarter, half and full widths exist).
module bs_operand_mask
    import bitscan_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] raw,
    input  bs_size_e          size,
    output logic [DATA_W-1:0] masked
);
    localparam int Q_W = DATA_W / 4;
    localparam int H_W = DATA_W / 2;

    logic [DATA_W-1:0] keep;

    // Build the keep mask for the selected width.
    always_comb begin
        case (size)
            SZ_QUARTER: keep = {{(DATA_W-Q_W){1'b0}}, {Q_W{1'b1}}};
            SZ_HALF:    keep = {{(DATA_W-H_W){1'b0}}, {H_W{1'b1}}};
            default:    keep = {DATA_W{1'b1}};
        endcase
    end

    // Apply the mask.
    always_comb masked = raw & keep;

endmodule

// File: rtl/bs_bit_encoder.sv
// Module: bs_bit_encoder
// Parallel priority encoder: returns the index of the highest (FROM_TOP=1) or
// lowest (FROM_TOP=0) set bit of vec, and flags an all-zero vector. The search
// is a log-depth tree of pairwise selections, so delay does not depend on data.
// Assumes W is a power of two, at least 2.
module bs_bit_encoder #(
    parameter int W        = 64,
    parameter bit FROM_TOP = 1'b1
) (
    input  logic [W-1:0]         vec,
    output logic [$clog2(W)-1:0] idx,
    output logic                 none
);
    localparam int LVLS  = $clog2(W);
    localparam int NODES = 2 * W - 1;

    // Node n of the heap: any-bit-set flag and winning index; leaves at W-1..2W-2.
    logic [NODES-1:0] hit;
    logic [LVLS-1:0]  win [NODES];

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_leaf
            assign hit[W-1+g] = vec[g];
            assign win[W-1+g] = LVLS'(g);
        end
        for (g = W - 2; g >= 0; g--) begin : g_node
            // Left child covers lower indices, right child covers higher ones.
            if (FROM_TOP) begin : g_hi
                assign win[g] = hit[2*g+2] ? win[2*g+2] : win[2*g+1];
            end else begin : g_lo
                assign win[g] = hit[2*g+1] ? win[2*g+1] : win[2*g+2];
            end
            assign hit[g] = hit[2*g+1] | hit[2*g+2];
        end
    endgenerate

    // Root of the tree carries the answer.
    always_comb begin
        idx  = win[0];
        none = ~hit[0];
    end

endmodule

// File: rtl/bs_result_form.sv
// Module: bs_result_form
// Turns the encoder outputs into the architectural result and flags for one
// operation: index, count, kept destination, zero flag and carry flag.
// Assumes msb/lsb are meaningful only when empty is low.
module bs_result_form
    import bitscan_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  bs_op_e                    op,
    input  bs_size_e                  size,
    input  logic                      empty,
    input  logic [$clog2(DATA_W)-1:0] msb,
    input  logic [$clog2(DATA_W)-1:0] lsb,
    input  logic [DATA_W-1:0]         dst_old,
    output logic [DATA_W-1:0]         result,
    output logic                      zf,
    output logic                      cf
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int CNT_W = IDX_W + 1;

    logic [CNT_W-1:0] width;
    logic [CNT_W-1:0] lead;
    logic [CNT_W-1:0] count;

    // Selected operand width and leading-zero count relative to it.
    always_comb begin
        width = CNT_W'(sel_bits(size, DATA_W));
        lead  = width - CNT_W'(1) - {1'b0, msb};
    end

    // Pick the result and flags by operation.
    always_comb begin
        count  = '0;
        result = '0;
        zf     = 1'b0;
        cf     = 1'b0;
        case (op)
            OP_SCAN_FWD, OP_SCAN_REV: begin
                zf = empty;
                if (empty) begin
                    result = dst_old;
                end else begin
                    result = {{(DATA_W-IDX_W){1'b0}}, (op == OP_SCAN_FWD) ? lsb : msb};
                end
            end
            default: begin
                if (empty) begin
                    count = width;
                end else if (op == OP_LEAD_ZC) begin
                    count = lead;
                end else begin
                    count = {1'b0, lsb};
                end
                cf     = empty;
                zf     = (count == '0);
                result = {{(DATA_W-CNT_W){1'b0}}, count};
            end
        endcase
    end

endmodule

// File: rtl/bitscan_unit.sv
// Module: bitscan_unit (top)
// Three-stage bit-scan and zero-count pipeline. Stage 1 registers the masked
// operand, stage 2 registers both priority-encoder results, stage 3 registers
// the formed result and flags. One operation per cycle, fixed 3-cycle latency.
// Assumes DATA_W is a power of two and at least 8.
module bitscan_unit
    import bitscan_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [1:0]        in_size,
    input  logic [DATA_W-1:0] in_src,
    input  logic [DATA_W-1:0] in_dst_old,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_zf,
    output logic              out_cf
);
    localparam int IDX_W = $clog2(DATA_W);

    // Stage 1 state
    logic              s1_valid;
    bs_op_e            s1_op;
    bs_size_e          s1_size;
    logic [DATA_W-1:0] s1_data;
    logic [DATA_W-1:0] s1_old;
    logic [DATA_W-1:0] masked;

    // Stage 2 state
    logic              s2_valid;
    bs_op_e            s2_op;
    bs_size_e          s2_size;
    logic [DATA_W-1:0] s2_old;
    logic [IDX_W-1:0]  s2_msb;
    logic [IDX_W-1:0]  s2_lsb;
    logic              s2_empty;
    logic [IDX_W-1:0]  enc_msb;
    logic [IDX_W-1:0]  enc_lsb;
    logic              enc_none_hi;
    logic              enc_none_lo;

    // Stage 3 inputs
    logic [DATA_W-1:0] form_result;
    logic              form_zf;
    logic              form_cf;

    // The pipeline never stalls.
    assign in_ready = 1'b1;

    bs_operand_mask #(.DATA_W(DATA_W)) u_mask (
        .raw    (in_src),
        .size   (bs_size_e'(in_size)),
        .masked (masked)
    );

    // Stage 1: capture the operation with the operand already trimmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_op    <= OP_SCAN_FWD;
            s1_size  <= SZ_QUARTER;
            s1_data  <= '0;
            s1_old   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_op    <= bs_op_e'(in_op);
            s1_size  <= bs_size_e'(in_size);
            s1_data  <= masked;
            s1_old   <= in_dst_old;
        end
    end

    bs_bit_encoder #(.W(DATA_W), .FROM_TOP(1'b1)) u_enc_hi (
        .vec  (s1_data),
        .idx  (enc_msb),
        .none (enc_none_hi)
    );

    bs_bit_encoder #(.W(DATA_W), .FROM_TOP(1'b0)) u_enc_lo (
        .vec  (s1_data),
        .idx  (enc_lsb),
        .none (enc_none_lo)
    );

    // Stage 2: capture both encoder results and the empty indication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_op    <= OP_SCAN_FWD;
            s2_size  <= SZ_QUARTER;
            s2_old   <= '0;
            s2_msb   <= '0;
            s2_lsb   <= '0;
            s2_empty <= 1'b0;
        end else begin
            s2_valid <= s1_valid;
            s2_op    <= s1_op;
            s2_size  <= s1_size;
            s2_old   <= s1_old;
            s2_msb   <= enc_msb;
            s2_lsb   <= enc_lsb;
            s2_empty <= enc_none_hi & enc_none_lo;
        end
    end

    bs_result_form #(.DATA_W(DATA_W)) u_form (
        .op      (s2_op),
        .size    (s2_size),
        .empty   (s2_empty),
        .msb     (s2_msb),
        .lsb     (s2_lsb),
        .dst_old (s2_old),
        .result  (form_result),
        .zf      (form_zf),
        .cf      (form_cf)
    );

    // Stage 3: register the architectural outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_zf     <= 1'b0;
            out_cf     <= 1'b0;
        end else begin
            out_valid  <= s2_valid;
            out_result <= form_result;
            out_zf     <= form_zf;
            out_cf     <= form_cf;
        end
    end

endmodule

// File: rtl/bitscan_unit_checker.sv
// Module: bitscan_unit_checker
// Temporal properties of the bit-scan unit, bound to every instance of the top.
// Assumes the 3-cycle latency; a warm-up counter keeps $past inside the cycles
// that follow reset.
module bitscan_unit_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [1:0]        in_op,
    input logic [1:0]        in_size,
    input logic [DATA_W-1:0] in_src,
    input logic [DATA_W-1:0] in_dst_old,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_zf,
    input logic              out_cf
);
    logic [1:0] warm;

    // Count edges since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)            warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    p_valid_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    p_always_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> in_ready);

    p_scan_keeps_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm == 2'd3) && $past(in_valid, 3) && !$past(in_op[1], 3)
         && ($past(in_src, 3) == '0))
        |-> (out_result == $past(in_dst_old, 3)) && out_zf && !out_cf);

    p_count_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm == 2'd3) && $past(in_valid, 3) && $past(in_op[1], 3)
         && ($past(in_src, 3) == '0))
        |-> out_cf && (out_result >= DATA_W'(16)) && (out_result <= DATA_W'(DATA_W)));

    p_scan_no_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm == 2'd3) && out_valid && !$past(in_op[1], 3)) |-> !out_cf);

    p_count_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm == 2'd3) && out_valid && $past(in_op[1], 3))
        |-> (out_zf == (out_result == '0)));

    p_reset_clears_r10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_zf && !out_cf && (out_result == '0)));

endmodule

bind bitscan_unit bitscan_unit_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_op      (in_op),
    .in_size    (in_size),
    .in_src     (in_src),
    .in_dst_old (in_dst_old),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_zf     (out_zf),
    .out_cf     (out_cf)
);

// File: tb/bitscan_unit_test.sv
// Bench: sweeps all bit-pair sources over every op and size, then streams
// back-to-back operations. Expected values come from an arithmetic model.
module bitscan_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_op = 2'b00;
    logic [1:0]  in_size = 2'b00;
    logic [63:0] in_src = '0;
    logic [63:0] in_dst_old = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_zf;
    logic        out_cf;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bitscan_unit #(.DATA_W(64)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_size(in_size), .in_src(in_src), .in_dst_old(in_dst_old),
        .out_valid(out_valid), .out_result(out_result), .out_zf(out_zf), .out_cf(out_cf)
    );

    // Reference: width by size code, then arithmetic scan of the trimmed value.
    function automatic void model(input logic [1:0] op, input logic [1:0] sz,
                                  input logic [63:0] src, input logic [63:0] old,
                                  output logic [63:0] r, output logic zf, output logic cf);
        int w;
        int hi;
        int lo;
        w  = (sz == 2'b00) ? 16 : (sz == 2'b01) ? 32 : 64;
        hi = -1;
        lo = -1;
        for (int b = 0; b < w; b++) begin
            if (src[b]) begin
                hi = b;
                if (lo < 0) lo = b;
            end
        end
        cf = 1'b0;
        if (op[1] == 1'b0) begin
            zf = (hi < 0);
            r  = (hi < 0) ? old : 64'((op == 2'b00) ? lo : hi);
        end else begin
            if (hi < 0) begin
                r  = 64'(w);
                cf = 1'b1;
            end else begin
                r = 64'((op == 2'b10) ? (w - 1 - hi) : lo);
            end
            zf = (r == 64'd0);
        end
    endfunction

    task automatic compare(input string req, input logic [63:0] er,
                           input logic ezf, input logic ecf);
        checks++;
        if (out_valid !== 1'b1 || out_result !== er || out_zf !== ezf || out_cf !== ecf) begin
            errors++;
            $display("FAIL %s: got v=%b r=%h zf=%b cf=%b, expected v=1 r=%h zf=%b cf=%b",
                     req, out_valid, out_result, out_zf, out_cf, er, ezf, ecf);
        end
    endtask

    // Issue one operation alone and check it three cycles later.
    task automatic run_one(input string req, input logic [1:0] op, input logic [1:0] sz,
                           input logic [63:0] src, input logic [63:0] old);
        logic [63:0] er;
        logic ezf;
        logic ecf;
        model(op, sz, src, old, er, ezf, ecf);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_size = sz; in_src = src; in_dst_old = old;
        @(negedge clk);
        in_valid = 1'b0; in_src = ~src; in_dst_old = ~old;
        @(negedge clk);
        @(negedge clk);
        compare(req, er, ezf, ecf);
    endtask

    function automatic string req_of(input logic [1:0] op, input logic zero);
        if (op == 2'b00) return zero ? "R3 fwd-scan empty" : "R1 R8 fwd-scan";
        if (op == 2'b01) return zero ? "R3 rev-scan empty" : "R2 R8 rev-scan";
        if (op == 2'b10) return zero ? "R5 lead-count empty" : "R4 R7 R8 lead-count";
        return zero ? "R5 trail-count empty" : "R6 R7 R8 trail-count";
    endfunction

    localparam int N_STREAM = 40;

    initial begin
        logic [63:0] sr [N_STREAM];
        logic [63:0] se [N_STREAM];
        logic        sz_e [N_STREAM];
        logic        sc_e [N_STREAM];
        logic [63:0] junk;

        repeat (4) @(negedge clk);
        // R10: outputs cleared during reset.
        checks++;
        if (out_valid !== 1'b0 || out_result !== 64'd0 || out_zf !== 1'b0 || out_cf !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset: got v=%b r=%h zf=%b cf=%b, expected all zero",
                     out_valid, out_result, out_zf, out_cf);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: the worked example, 0x24 at 16 bits.
        run_one("R2 example 0x24", 2'b01, 2'b00, 64'h24, 64'h77);
        // R3 / R5: all-zero sources, every size.
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++)
                run_one(req_of(2'(o), 1'b1), 2'(o), 2'(s), 64'd0, 64'hFEED_0000_1111_2222);

        // R1 R2 R4 R5 R6 R7 R8: every bit pair, junk above the selected width.
        for (int s = 0; s < 3; s++) begin
            int w;
            w = (s == 0) ? 16 : (s == 1) ? 32 : 64;
            junk = (w == 64) ? 64'd0 : (64'hDEAD_BEEF_F00D_CAFE & ~((64'd1 << w) - 64'd1));
            for (int i = 0; i < 64; i++) begin
                for (int j = i; j < 64; j++) begin
                    logic [63:0] src;
                    src = (64'd1 << i) | (64'd1 << j) | junk;
                    for (int o = 0; o < 4; o++)
                        run_one(req_of(2'(o), (i >= w)), 2'(o), 2'(s), src,
                                64'h1234_5678_9ABC_DEF0 ^ 64'(i * 97 + j));
                end
            end
        end
        // R8: size code 2'b11 behaves as 64 bits.
        for (int i = 0; i < 64; i++)
            for (int o = 0; o < 4; o++)
                run_one("R8 size code 11", 2'(o), 2'b11, 64'd1 << i, 64'h55);

        // R9: back-to-back stream, results in order three cycles later.
        for (int c = 0; c < N_STREAM + 3; c++) begin
            @(negedge clk);
            if (c >= 3) compare("R9 stream", sr[c-3], sz_e[c-3], sc_e[c-3]);
            if (c < N_STREAM) begin
                logic [63:0] src;
                src = (c % 7 == 0) ? 64'd0 : (64'h8000_0000_0000_0001 >> (c % 61)) | (64'd1 << (c % 13));
                in_valid = 1'b1;
                in_op = 2'(c % 4);
                in_size = 2'(c % 3);
                in_src = src;
                in_dst_old = 64'hABCD_0000_0000_0000 | 64'(c);
                model(in_op, in_size, src, in_dst_old, sr[c], sz_e[c], sc_e[c]);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        // R9: idle input gives idle output.
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9 idle: got v=%b, expected v=0", out_valid);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule